// File: doc/BRIEF.md
# Per-Packet Unique IV Source

This block hands out 64-bit initialisation values for counter-mode packet encryption. The receiver treats each value as opaque, so the only rule is that no value repeats under one key. Several cores or chips can serve the same security association without sharing any changing state. Each unit gets a small, distinct identifier that fills the top bits of every value it emits. The lower bits come from a local sequence register. The identifier width is a parameter. A single-core build sets it to zero, so the whole value is sequence.

The sequence register runs in one of two ways, chosen by a parameter. It can be a plain binary counter, which is easy to read but has a carry chain. It can also be a maximal-length shift register, whose next-state logic is a few XOR gates at any width. That suits a consumer that may need a fresh value every cipher round. Values leave on a valid/ready stream. `iv_valid` never depends on `iv_ready`. A value is taken on a rising edge where both are high. While the consumer holds `iv_ready` low, the offered value and its valid stay frozen for as long as needed. Before any value could repeat, the block raises `exhausted` and withdraws `iv_valid` until the next reset.

Top module: `iv_unique_gen`

## Requirements
- R1: `iv_data` is the identifier field in its top `ID_W` bits, above the sequence field in the low `SEQ_W = IV_W - ID_W` bits. With `ID_W = 0` the whole value is sequence. `ID_W` lies in 0..8 and `IV_W` is at least 8.
- R2: The identifier field is `core_id[ID_W-1:0]`, captured on every rising edge while `rst` is high. Changes on `core_id` after reset have no effect on `iv_data`.
- R3: A transfer happens on a rising edge with `iv_valid` and `iv_ready` both high. The sequence field changes exactly once per transfer and never otherwise.
- R4: While `iv_valid` is high and `iv_ready` is low, `iv_data` and `iv_valid` hold their values on the next cycle.
- R5: In counter mode (`MODE = SEQ_COUNT`) the sequence field is 0 after reset and increases by one per transfer.
- R6: In shift-register mode (`MODE = SEQ_LFSR`) the sequence field is `SEED` after reset. Each transfer loads `{s[SEQ_W-2:0], f}`, where `f` is the XOR of the tapped bits. For `SEQ_W = 8` the taps are bits 7, 5, 4 and 3. The field is never zero. `SEQ_W` must be one of 2..24, 28, 31, 32 or 56..64.
- R7: In counter mode, after 2^SEQ_W transfers `exhausted` goes high and `iv_valid` goes low.
- R8: In shift-register mode, after 2^SEQ_W - 1 transfers `exhausted` goes high and `iv_valid` goes low.
- R9: While `rst` is high, and on the first edge after it, `iv_valid` and `exhausted` are low. `iv_valid` rises one cycle after `rst` falls. `exhausted` stays high until the next reset.
- R10: All values transferred between two resets are distinct.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also captures `core_id` |
| core_id | input | 8 | Static unit identifier; low `ID_W` bits used |
| iv_valid | output | 1 | A fresh value is offered |
| iv_ready | input | 1 | Consumer takes the offered value this edge |
| iv_data | output | IV_W | Offered value: identifier over sequence |
| exhausted | output | 1 | Sequence space used up; no more values |

## Verification
Two instances run side by side. One is a 12-bit counter build with a 4-bit identifier. The other is an 8-bit shift-register build with no identifier. The consumer first takes a value every cycle, which shows the one-step-per-edge advance. It then takes every other cycle, which separates advancing on a transfer from advancing on each clock. A long stall shows that held values stay put under back-pressure. A pseudo-random ready pattern then runs until both instances run dry. That exposes an off-by-one in the exhaustion count, which is 256 transfers for the counter and 255 for the shift register. Every transferred shift-register value is checked against all earlier ones for repeats and for zero. The identifier input is changed after reset to show it is ignored. A second reset with a new identifier shows that reset clears the flag, reloads the start value and captures the new identifier.

// File: rtl/iv_gen_pkg.sv
package iv_gen_pkg;

  typedef enum logic [0:0] {
    SEQ_COUNT = 1'b0,
    SEQ_LFSR  = 1'b1
  } seq_mode_e;

  localparam int unsigned ID_PORT_W = 8;

  // Feedback positions (1-based) of a maximal-length XOR shift register.
  // Unused slots are zero.
  function automatic logic [63:0] lfsr_taps(input int unsigned n);
    int unsigned p0, p1, p2, p3;
    logic [63:0] m;
    p0 = 0; p1 = 0; p2 = 0; p3 = 0;
    case (n)
      2:  begin p0 = 2;  p1 = 1;  end
      3:  begin p0 = 3;  p1 = 2;  end
      4:  begin p0 = 4;  p1 = 3;  end
      5:  begin p0 = 5;  p1 = 3;  end
      6:  begin p0 = 6;  p1 = 5;  end
      7:  begin p0 = 7;  p1 = 6;  end
      8:  begin p0 = 8;  p1 = 6;  p2 = 5;  p3 = 4;  end
      9:  begin p0 = 9;  p1 = 5;  end
      10: begin p0 = 10; p1 = 7;  end
      11: begin p0 = 11; p1 = 9;  end
      12: begin p0 = 12; p1 = 6;  p2 = 4;  p3 = 1;  end
      13: begin p0 = 13; p1 = 4;  p2 = 3;  p3 = 1;  end
      14: begin p0 = 14; p1 = 5;  p2 = 3;  p3 = 1;  end
      15: begin p0 = 15; p1 = 14; end
      16: begin p0 = 16; p1 = 15; p2 = 13; p3 = 4;  end
      17: begin p0 = 17; p1 = 14; end
      18: begin p0 = 18; p1 = 11; end
      19: begin p0 = 19; p1 = 6;  p2 = 2;  p3 = 1;  end
      20: begin p0 = 20; p1 = 17; end
      21: begin p0 = 21; p1 = 19; end
      22: begin p0 = 22; p1 = 21; end
      23: begin p0 = 23; p1 = 18; end
      24: begin p0 = 24; p1 = 23; p2 = 22; p3 = 17; end
      28: begin p0 = 28; p1 = 25; end
      31: begin p0 = 31; p1 = 28; end
      32: begin p0 = 32; p1 = 22; p2 = 2;  p3 = 1;  end
      56: begin p0 = 56; p1 = 55; p2 = 35; p3 = 34; end
      57: begin p0 = 57; p1 = 50; end
      58: begin p0 = 58; p1 = 39; end
      59: begin p0 = 59; p1 = 58; p2 = 38; p3 = 37; end
      60: begin p0 = 60; p1 = 59; end
      61: begin p0 = 61; p1 = 60; p2 = 46; p3 = 45; end
      62: begin p0 = 62; p1 = 61; p2 = 6;  p3 = 5;  end
      63: begin p0 = 63; p1 = 62; end
      64: begin p0 = 64; p1 = 63; p2 = 61; p3 = 60; end
      default: begin p0 = 0; end
    endcase
    m = '0;
    if (p0 != 0) m[p0-1] = 1'b1;
    if (p1 != 0) m[p1-1] = 1'b1;
    if (p2 != 0) m[p2-1] = 1'b1;
    if (p3 != 0) m[p3-1] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/iv_id_latch.sv
module iv_id_latch
  import iv_gen_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ID_PORT_W-1:0] id_in,
  output logic [ID_PORT_W-1:0] id_q
);

  // Identifier is only loaded while reset is held; afterwards it is frozen.
  always_ff @(posedge clk) begin
    if (rst) id_q <= id_in;
  end

endmodule

// File: rtl/iv_seq_counter.sv
module iv_seq_counter #(
  parameter int unsigned SEQ_W = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [SEQ_W-1:0] seq,
  output logic             last
);

  logic [SEQ_W-1:0] seq_q;

  always_ff @(posedge clk) begin
    if (rst)      seq_q <= '0;
    else if (adv) seq_q <= seq_q + 1'b1;
  end

  assign seq  = seq_q;
  // The all-ones value is the final one before the count would wrap.
  assign last = &seq_q;

endmodule

// File: rtl/iv_seq_lfsr.sv
module iv_seq_lfsr
  import iv_gen_pkg::*;
#(
  parameter int unsigned SEQ_W = 60,
  parameter logic [63:0] SEED  = 64'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [SEQ_W-1:0] seq,
  output logic             last
);

  localparam logic [63:0]      TAP_ALL  = lfsr_taps(SEQ_W);
  localparam logic [SEQ_W-1:0] TAP_MASK = TAP_ALL[SEQ_W-1:0];
  localparam logic [SEQ_W-1:0] START    = SEED[SEQ_W-1:0];

  logic [SEQ_W-1:0] seq_q;
  logic [SEQ_W-1:0] seq_nx;
  logic             fb;

  // Feedback depth is one XOR tree over at most four bits, whatever the width.
  always_comb begin
    fb     = ^(seq_q & TAP_MASK);
    seq_nx = {seq_q[SEQ_W-2:0], fb};
  end

  always_ff @(posedge clk) begin
    if (rst)      seq_q <= START;
    else if (adv) seq_q <= seq_nx;
  end

  assign seq  = seq_q;
  // The cycle closes when the successor would be the start value again.
  assign last = (seq_nx == START);

endmodule

// File: rtl/iv_issue_ctrl.sv
module iv_issue_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic last,
  output logic live,
  output logic done
);

  logic live_q;
  logic done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (take && last) done_q <= 1'b1;
    end
  end

  assign live = live_q;
  assign done = done_q;

endmodule

// File: rtl/iv_unique_gen.sv
module iv_unique_gen
  import iv_gen_pkg::*;
#(
  parameter int unsigned IV_W = 64,
  parameter int unsigned ID_W = 4,
  parameter seq_mode_e   MODE = SEQ_COUNT,
  parameter logic [63:0] SEED = 64'd1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ID_PORT_W-1:0] core_id,
  output logic                 iv_valid,
  input  logic                 iv_ready,
  output logic [IV_W-1:0]      iv_data,
  output logic                 exhausted
);

  localparam int unsigned SEQ_W = IV_W - ID_W;
  localparam logic [ID_PORT_W-1:0] ID_MASK =
      ID_PORT_W'((9'd1 << ID_W) - 9'd1);

  logic [ID_PORT_W-1:0] id_q;
  logic [SEQ_W-1:0]     seq;
  logic                 last;
  logic                 live;
  logic                 done;
  logic                 take;

  iv_id_latch u_id (
    .clk   (clk),
    .rst   (rst),
    .id_in (core_id),
    .id_q  (id_q)
  );

  generate
    if (MODE == SEQ_LFSR) begin : g_lfsr
      iv_seq_lfsr #(.SEQ_W(SEQ_W), .SEED(SEED)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .adv  (take),
        .seq  (seq),
        .last (last)
      );
    end else begin : g_count
      iv_seq_counter #(.SEQ_W(SEQ_W)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .adv  (take),
        .seq  (seq),
        .last (last)
      );
    end
  endgenerate

  iv_issue_ctrl u_ctrl (
    .clk  (clk),
    .rst  (rst),
    .take (take),
    .last (last),
    .live (live),
    .done (done)
  );

  assign iv_valid  = live & ~done;
  assign take      = iv_valid & iv_ready;
  assign exhausted = done;

  // Identifier shifted above the sequence; with ID_W = 0 the mask clears it.
  assign iv_data = (IV_W'(id_q & ID_MASK) << SEQ_W) | IV_W'(seq);

endmodule

// File: rtl/iv_unique_gen_chk.sv
module iv_unique_gen_chk
  import iv_gen_pkg::*;
#(
  parameter int unsigned IV_W = 64,
  parameter int unsigned ID_W = 4,
  parameter seq_mode_e   MODE = SEQ_COUNT
) (
  input logic            clk,
  input logic            rst,
  input logic            iv_valid,
  input logic            iv_ready,
  input logic [IV_W-1:0] iv_data,
  input logic            exhausted
);

  localparam int unsigned SEQ_W = IV_W - ID_W;

  // R4: offered value and valid frozen under back-pressure
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    iv_valid && !iv_ready |=> iv_valid && $stable(iv_data));

  // R3: a stalled value does not advance, a taken one does (unless space ran out)
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    iv_valid && iv_ready |=> exhausted || (iv_data[SEQ_W-1:0] != $past(iv_data[SEQ_W-1:0])));

  // R9: flag sticky until reset and no offer once raised
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    exhausted |=> exhausted);
  a_r9_no_offer: assert property (@(posedge clk) disable iff (rst)
    exhausted |-> !iv_valid);

  generate
    if (ID_W > 0) begin : g_id
      // R2: identifier field constant outside reset
      a_r2_id_static: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(iv_data[IV_W-1:SEQ_W]));
    end
    if (MODE == SEQ_LFSR) begin : g_lfsr
      // R6: the shift-register field never holds zero
      a_r6_nonzero: assert property (@(posedge clk) disable iff (rst)
        iv_valid |-> (iv_data[SEQ_W-1:0] != '0));
    end else begin : g_count
      // R5: counter steps by exactly one per transfer
      a_r5_plus_one: assert property (@(posedge clk) disable iff (rst)
        iv_valid && iv_ready |=>
          iv_data[SEQ_W-1:0] == SEQ_W'($past(iv_data[SEQ_W-1:0]) + 1'b1));
      // R7: taking the all-ones value ends the space
      a_r7_last_ends: assert property (@(posedge clk) disable iff (rst)
        iv_valid && iv_ready && (&iv_data[SEQ_W-1:0]) |=> exhausted);
    end
  endgenerate

endmodule

bind iv_unique_gen iv_unique_gen_chk #(.IV_W(IV_W), .ID_W(ID_W), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .iv_valid  (iv_valid),
  .iv_ready  (iv_ready),
  .iv_data   (iv_data),
  .exhausted (exhausted)
);

// File: tb/tb_iv_unique_gen.sv
module tb_iv_unique_gen;
  import iv_gen_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rdy = 1'b0;
  logic [7:0] core_id = 8'h3A;

  logic        c_valid, c_exh;
  logic [11:0] c_data;
  logic        l_valid, l_exh;
  logic [7:0]  l_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  // Counter build: 12-bit value, 4-bit identifier, 8-bit sequence
  iv_unique_gen #(.IV_W(12), .ID_W(4), .MODE(SEQ_COUNT)) dut (
    .clk(clk), .rst(rst), .core_id(core_id), .iv_valid(c_valid),
    .iv_ready(rdy), .iv_data(c_data), .exhausted(c_exh));

  // Shift-register build: 8-bit value, no identifier, start value 1
  iv_unique_gen #(.IV_W(8), .ID_W(0), .MODE(SEQ_LFSR), .SEED(64'd1)) dut_lf (
    .clk(clk), .rst(rst), .core_id(core_id), .iv_valid(l_valid),
    .iv_ready(rdy), .iv_data(l_data), .exhausted(l_exh));

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Reference state
  bit         m_live, m_done;
  int         m_cnt;
  logic [7:0] m_seq;
  logic [3:0] m_id;
  bit         n_live, n_done;
  int         n_cnt;
  logic [7:0] n_seq;
  bit         seen [256];
  int unsigned lcg = 32'h1234_5678;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    m_live = 0; m_done = 0; m_cnt = 0; m_seq = 0; m_id = 4'hA;
    n_live = 0; n_done = 0; n_cnt = 0; n_seq = 8'd1;
    @(negedge clk);
    for (int cyc = 0; cyc < 1130; cyc++) begin
      bit r, q, c_fire, l_fire;
      // Compare outputs against the model state after the last edge
      if (cyc == 2) begin
        chk("R9", "reset valid", c_valid, 0);
        chk("R9", "reset exhausted", c_exh, 0);
      end
      chk("R1", "ctr data", c_data, {m_id, m_seq});
      chk("R7", "ctr valid", c_valid, m_live && !m_done);
      chk("R7", "ctr exhausted", c_exh, m_done);
      chk("R6", "lfsr data", l_data, n_seq);
      chk("R8", "lfsr valid", l_valid, n_live && !n_done);
      chk("R8", "lfsr exhausted", l_exh, n_done);
      if (cyc == 1099) begin
        chk("R7", "ctr used up after 256", m_cnt, 256);
        chk("R8", "lfsr used up after 255", n_cnt, 255);
      end

      // Choose next inputs
      r = (cyc < 3) || (cyc >= 1100 && cyc < 1103);
      if (cyc < 43)       q = 1;
      else if (cyc < 63)  q = cyc[0];
      else if (cyc < 76)  q = 0;            // long stall, R4
      else if (cyc < 1090) begin
        lcg = lcg * 32'd1103515245 + 32'd12345;
        q = lcg[16];
      end else            q = 1;
      if (cyc == 5)    core_id = 8'h35;     // ignored, R2
      if (cyc == 1095) core_id = 8'hC3;     // captured by the second reset
      rst = r;
      rdy = q;
      c_fire = !r && q && m_live && !m_done;
      l_fire = !r && q && n_live && !n_done;

      @(posedge clk);
      if (r) begin
        m_live = 0; m_done = 0; m_cnt = 0; m_seq = 0; m_id = core_id[3:0];
        n_live = 0; n_done = 0; n_cnt = 0; n_seq = 8'd1;
        foreach (seen[i]) seen[i] = 0;
      end else begin
        m_live = 1;
        n_live = 1;
        if (c_fire) begin
          m_cnt++;
          m_seq = m_seq + 8'd1;
          if (m_cnt == 256) m_done = 1;
        end
        if (l_fire) begin
          // R10: each taken value is new and nonzero
          chk("R10", "lfsr repeat", seen[n_seq], 0);
          chk("R6", "lfsr zero", (n_seq == 8'd0), 0);
          seen[n_seq] = 1;
          n_cnt++;
          n_seq = {n_seq[6:0], n_seq[7] ^ n_seq[5] ^ n_seq[4] ^ n_seq[3]};
          if (n_cnt == 255) n_done = 1;
        end
      end
      @(negedge clk);
    end
    chk("R2", "new id after second reset", c_data[11:8], 4'h3);
    chk("R5", "counter moved after second reset", c_data[7:0], m_seq);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule